// File: doc/BRIEF.md
# Memory Test Command Generator

This block feeds an external memory controller with a stream of test commands. Each command carries an instruction (write or read), an address and a data word. Software or a sequencer sets the configuration inputs and pulses a one-cycle load strobe. The block then captures the address, instruction, burst and data mode selections together with the address window, the fixed values and an eight-word repeat set, and starts issuing commands on a valid/ready port.

Addresses either walk upward through the window in fixed strides or are drawn from a pseudo-random generator and folded into the window. Instructions come from a fixed input or from the same pseudo-random source. They are grouped into bursts of back-to-back commands that share one instruction. The data word can be the command address, a fixed word, or one of eight user words replayed in order.

A sequential run ends on its own with a one-cycle done pulse. A pseudo-random run continues until the next load. Checking of read data is done elsewhere.

Top module: `mtg_traffic_gen`

## Requirements
- R1: After reset, cmd_valid_o and done_o are low, and no command is issued until load_i has been pulsed.
- R2: The configuration inputs are captured only on a cycle where load_i is high. Changes to them at other times do not alter the command stream that is running.
- R3: With address mode 2'b11, command addresses run start, start+ADDR_STEP, start+2*ADDR_STEP and so on (ADDR_STEP defaults to 8). The last command carries the highest such address not above the end address. done_o is high for exactly one cycle, the cycle after that last command is accepted, and cmd_valid_o stays low afterwards.
- R4: With any other address mode, addresses come from a 32-bit left-shifting LFSR with a nonzero seed, whose new bit is the XOR of bits 31, 21, 1 and 0. Each value is folded into the inclusive window from start to end. The stream keeps running until the next load, and done_o does not pulse.
- R5: With instruction mode 4'b0001, every command carries cfg_fixed_instr_i. With any other code, each burst is given 3'b000 (write) or 3'b001 (read) from the LFSR, and both values occur over a long run.
- R6: With burst mode 2'b01 and a nonzero fixed burst value N, commands come in groups of N back-to-back commands that share one instruction. The first group starts with the first command after the load. Other burst codes draw the group length from the LFSR.
- R7: With data mode 4'b0010, the data word equals the command address.
- R8: With data mode 4'b0001, the data word equals cfg_fixed_data_i.
- R9: With any other data mode, the data word is word k of cfg_rep_data_i, taken from bits [32k+31:32k]. k is the number of commands accepted since the load, modulo 8.
- R10: While cmd_valid_o is high and cmd_ready_i is low, cmd_valid_o, cmd_instr_o, cmd_addr_o and cmd_data_o keep their values until the command is accepted.
- R11: A load during a run abandons the pending command. cmd_valid_o is low in the cycle after the load edge, and the first command of the new configuration appears after the second rising edge following the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load_i | input | 1 | One-cycle strobe that captures the configuration and starts a run |
| cfg_addr_mode_i | input | 2 | Address source: 2'b11 sequential, other codes pseudo-random |
| cfg_instr_mode_i | input | 4 | Instruction source: 4'b0001 fixed, other codes pseudo-random |
| cfg_burst_mode_i | input | 2 | Burst length source: 2'b01 fixed, other codes pseudo-random |
| cfg_data_mode_i | input | 4 | Data source: 4'b0001 fixed, 4'b0010 address, other codes eight-word repeat |
| cfg_start_addr_i | input | 32 | Lower bound of the address window |
| cfg_end_addr_i | input | 32 | Upper bound of the address window, inclusive |
| cfg_fixed_instr_i | input | 3 | Fixed instruction (3'b000 write, 3'b001 read) |
| cfg_fixed_burst_i | input | 6 | Fixed number of back-to-back commands per burst |
| cfg_fixed_data_i | input | 32 | Fixed data word |
| cfg_rep_data_i | input | 256 | Eight repeat data words, word k in bits [32k+31:32k] |
| cmd_valid_o | output | 1 | A command is presented |
| cmd_ready_i | input | 1 | Downstream accepts the presented command |
| cmd_instr_o | output | 3 | Command instruction |
| cmd_addr_o | output | 32 | Command address |
| cmd_data_o | output | 32 | Command data word |
| done_o | output | 1 | One-cycle pulse after the final command of a sequential run |

## Verification
On every cycle, the assertions check several rules. A stalled command holds steady, and every address lies inside the captured window. A fixed instruction mode is honoured. The generator state never reaches zero. done_o only follows an accepted command and leaves the port idle. The cycle after a load presents nothing. Only the bench scenarios can show the rest. These cover the exact sequential address list and where it stops, the order of the repeat data words, the grouping of instructions into bursts of the fixed length, the mix of writes and reads, and the immunity of a running stream to configuration changes made without a load.

// File: rtl/mtg_pkg.sv
package mtg_pkg;
  localparam logic [1:0] ADDR_MODE_SEQ    = 2'b11;
  localparam logic [3:0] INSTR_MODE_FIXED = 4'b0001;
  localparam logic [1:0] BURST_MODE_FIXED = 2'b01;
  localparam logic [3:0] DATA_MODE_FIXED  = 4'b0001;
  localparam logic [3:0] DATA_MODE_ADDR   = 4'b0010;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRIME = 2'd1,
    ST_RUN   = 2'd2
  } run_state_e;
endpackage

// File: rtl/mtg_lfsr.sv
module mtg_lfsr #(
  parameter int          LW   = 32,
  parameter logic [31:0] TAPS = 32'h8020_0003,
  parameter logic [31:0] SEED = 32'h1ACE_5EED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reseed_i,
  input  logic          step_i,
  output logic [LW-1:0] state_o
);
  logic [LW-1:0] lfsr_q, lfsr_d;

  always_comb begin
    lfsr_d = lfsr_q;
    if (reseed_i) begin
      lfsr_d = SEED[LW-1:0];
    end else if (step_i) begin
      lfsr_d = {lfsr_q[LW-2:0], ^(lfsr_q & TAPS[LW-1:0])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED[LW-1:0];
    else        lfsr_q <= lfsr_d;
  end

  assign state_o = lfsr_q;

  // R4: the generator never locks up in the all-zero state
  p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/mtg_addr_fold.sv
module mtg_addr_fold #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] rnd_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] span;
  logic [AW-1:0] mask;
  logic [AW-1:0] off_raw;
  logic [AW-1:0] off;

  assign span = hi_i - lo_i;

  for (genvar i = 0; i < AW; i++) begin : g_smear
    assign mask[i] = |span[AW-1:i];
  end

  assign off_raw = rnd_i & mask;

  always_comb begin
    if (off_raw > span) off = off_raw - span - AW'(1);
    else                off = off_raw;
  end

  assign addr_o = lo_i + off;
endmodule

// File: rtl/mtg_data_sel.sv
module mtg_data_sel
  import mtg_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  localparam int IDXW = $clog2(WORDS)
) (
  input  logic [3:0]          mode_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [DW-1:0]       fixed_i,
  input  logic [WORDS*DW-1:0] rep_i,
  input  logic [IDXW-1:0]     idx_i,
  output logic [DW-1:0]       data_o
);
  logic [DW-1:0] words [WORDS];

  for (genvar k = 0; k < WORDS; k++) begin : g_unpack
    assign words[k] = rep_i[k*DW +: DW];
  end

  always_comb begin
    case (mode_i)
      DATA_MODE_ADDR:  data_o = DW'(addr_i);
      DATA_MODE_FIXED: data_o = fixed_i;
      default:         data_o = words[idx_i];
    endcase
  end
endmodule

// File: rtl/mtg_traffic_gen.sv
module mtg_traffic_gen
  import mtg_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          IW        = 3,
  parameter int          BW        = 6,
  parameter int          REP_WORDS = 8,
  parameter int          ADDR_STEP = 8,
  parameter logic [31:0] LFSR_SEED = 32'h1ACE_5EED,
  localparam int         LW        = 32,
  localparam int         IDXW      = $clog2(REP_WORDS),
  localparam int         REPW      = REP_WORDS * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [1:0]      cfg_addr_mode_i,
  input  logic [3:0]      cfg_instr_mode_i,
  input  logic [1:0]      cfg_burst_mode_i,
  input  logic [3:0]      cfg_data_mode_i,
  input  logic [AW-1:0]   cfg_start_addr_i,
  input  logic [AW-1:0]   cfg_end_addr_i,
  input  logic [IW-1:0]   cfg_fixed_instr_i,
  input  logic [BW-1:0]   cfg_fixed_burst_i,
  input  logic [DW-1:0]   cfg_fixed_data_i,
  input  logic [REPW-1:0] cfg_rep_data_i,
  output logic            cmd_valid_o,
  input  logic            cmd_ready_i,
  output logic [IW-1:0]   cmd_instr_o,
  output logic [AW-1:0]   cmd_addr_o,
  output logic [DW-1:0]   cmd_data_o,
  output logic            done_o
);
  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // configuration registers, enabled by the load strobe only
  logic [1:0]      amode_q;
  logic [3:0]      imode_q;
  logic [1:0]      bmode_q;
  logic [3:0]      dmode_q;
  logic [AW-1:0]   start_q, end_q;
  logic [IW-1:0]   finstr_q;
  logic [BW-1:0]   fburst_q;
  logic [DW-1:0]   fdata_q;
  logic [REPW-1:0] rep_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      amode_q  <= '0;
      imode_q  <= '0;
      bmode_q  <= '0;
      dmode_q  <= '0;
      start_q  <= '0;
      end_q    <= '0;
      finstr_q <= '0;
      fburst_q <= '0;
      fdata_q  <= '0;
      rep_q    <= '0;
    end else if (load_i) begin
      amode_q  <= cfg_addr_mode_i;
      imode_q  <= cfg_instr_mode_i;
      bmode_q  <= cfg_burst_mode_i;
      dmode_q  <= cfg_data_mode_i;
      start_q  <= cfg_start_addr_i;
      end_q    <= cfg_end_addr_i;
      finstr_q <= cfg_fixed_instr_i;
      fburst_q <= cfg_fixed_burst_i;
      fdata_q  <= cfg_fixed_data_i;
      rep_q    <= cfg_rep_data_i;
    end
  end

  // pseudo-random source
  logic [LW-1:0] rnd;
  logic          rnd_step;

  mtg_lfsr #(.LW(LW), .SEED(LFSR_SEED)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .reseed_i (load_i),
    .step_i   (rnd_step),
    .state_o  (rnd)
  );

  logic [AW-1:0] fold_addr;

  mtg_addr_fold #(.AW(AW)) u_fold (
    .rnd_i  (rnd[AW-1:0]),
    .lo_i   (start_q),
    .hi_i   (end_q),
    .addr_o (fold_addr)
  );

  // command state
  run_state_e      state_q, state_d;
  logic [AW-1:0]   addr_q, addr_d;
  logic [IW-1:0]   instr_q, instr_d;
  logic [BW-1:0]   left_q, left_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic            done_q, done_d;

  logic          seq_mode;
  logic          last_cmd;
  logic          fire;
  logic [IW-1:0] pick_instr;
  logic [BW-1:0] raw_count;
  logic [BW-1:0] pick_left;

  assign seq_mode = (amode_q == ADDR_MODE_SEQ);
  assign last_cmd = (addr_q >= end_q) || ((end_q - addr_q) < AW'(ADDR_STEP));
  assign fire     = cmd_valid_o && cmd_ready_i;

  always_comb begin
    if (imode_q == INSTR_MODE_FIXED) pick_instr = finstr_q;
    else                             pick_instr = IW'(rnd[LW-1]);
    if (bmode_q == BURST_MODE_FIXED) raw_count = fburst_q;
    else                             raw_count = rnd[LW-2 -: BW];
    if (raw_count == '0) pick_left = '0;
    else                 pick_left = raw_count - BW'(1);
  end

  always_comb begin
    state_d  = state_q;
    addr_d   = addr_q;
    instr_d  = instr_q;
    left_d   = left_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    rnd_step = 1'b0;
    if (load_i) begin
      state_d = ST_PRIME;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_PRIME: begin
          state_d  = ST_RUN;
          addr_d   = seq_mode ? start_q : fold_addr;
          instr_d  = pick_instr;
          left_d   = pick_left;
          rnd_step = 1'b1;
        end
        ST_RUN: begin
          if (fire) begin
            rnd_step = 1'b1;
            idx_d    = (idx_q == IDXW'(REP_WORDS - 1)) ? '0 : idx_q + IDXW'(1);
            if (seq_mode && last_cmd) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              addr_d = seq_mode ? addr_q + AW'(ADDR_STEP) : fold_addr;
              if (left_q == '0) begin
                instr_d = pick_instr;
                left_d  = pick_left;
              end else begin
                left_d  = left_q - BW'(1);
              end
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      instr_q <= '0;
      left_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      instr_q <= instr_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  mtg_data_sel #(.AW(AW), .DW(DW), .WORDS(REP_WORDS)) u_data (
    .mode_i  (dmode_q),
    .addr_i  (addr_q),
    .fixed_i (fdata_q),
    .rep_i   (rep_q),
    .idx_i   (idx_q),
    .data_o  (cmd_data_o)
  );

  assign cmd_valid_o = (state_q == ST_RUN);
  assign cmd_instr_o = instr_q;
  assign cmd_addr_o  = addr_q;
  assign done_o      = done_q;

  // R10: a stalled command holds every field
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_valid_o && !cmd_ready_i && !load_i |=>
      cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_instr_o) && $stable(cmd_data_o));

  // R4: presented addresses stay inside a well-formed window
  p_window_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_valid_o && (start_q <= end_q) |-> (cmd_addr_o >= start_q) && (cmd_addr_o <= end_q));

  // R5: fixed instruction mode presents the captured instruction
  p_fixed_instr_r5: assert property (@(posedge clk) disable iff (!rst_core_n)
    cmd_valid_o && (imode_q == INSTR_MODE_FIXED) |-> cmd_instr_o == finstr_q);

  // R3: done follows an accepted command and leaves the port idle
  p_done_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    fire && !load_i |=> !done_o || !cmd_valid_o);

  p_done_src_r3: assert property (@(posedge clk) disable iff (!rst_core_n)
    !fire || load_i |=> !done_o);

  // R11: the cycle after a load presents no command
  p_reload_gap_r11: assert property (@(posedge clk) disable iff (!rst_core_n)
    load_i |=> !cmd_valid_o);
endmodule

// File: tb/mtg_traffic_gen_bench.sv
`timescale 1ns/1ps
module mtg_traffic_gen_bench;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         load_i;
  logic [1:0]   amode;
  logic [3:0]   imode;
  logic [1:0]   bmode;
  logic [3:0]   dmode;
  logic [31:0]  start_a, end_a;
  logic [2:0]   finstr;
  logic [5:0]   fburst;
  logic [31:0]  fdata;
  logic [255:0] rep;
  logic         cmd_valid, cmd_ready;
  logic [2:0]   cmd_instr;
  logic [31:0]  cmd_addr, cmd_data;
  logic         done;

  always #2.5 clk = ~clk;

  mtg_traffic_gen u_mtg_traffic_gen (
    .clk               (clk),
    .rst_n             (rst_n),
    .load_i            (load_i),
    .cfg_addr_mode_i   (amode),
    .cfg_instr_mode_i  (imode),
    .cfg_burst_mode_i  (bmode),
    .cfg_data_mode_i   (dmode),
    .cfg_start_addr_i  (start_a),
    .cfg_end_addr_i    (end_a),
    .cfg_fixed_instr_i (finstr),
    .cfg_fixed_burst_i (fburst),
    .cfg_fixed_data_i  (fdata),
    .cfg_rep_data_i    (rep),
    .cmd_valid_o       (cmd_valid),
    .cmd_ready_i       (cmd_ready),
    .cmd_instr_o       (cmd_instr),
    .cmd_addr_o        (cmd_addr),
    .cmd_data_o        (cmd_data),
    .done_o            (done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // capture of accepted commands
  logic [31:0] cap_addr  [512];
  logic [31:0] cap_data  [512];
  logic [2:0]  cap_instr [512];
  int ncap = 0;
  int done_cnt = 0;
  bit done_valid = 1'b0;
  int hold_bad = 0;
  int stall_cnt = 0;
  bit stall_en = 1'b0;
  logic [15:0] sl = 16'hACE1;
  bit prev_stall = 1'b0;
  logic [31:0] p_addr, p_data;
  logic [2:0]  p_instr;

  function automatic logic [31:0] rep_word(int k);
    return 32'hC0DE_0000 | (32'(k) * 32'h0000_1111);
  endfunction

  task automatic chk(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (stall_en) begin
      sl = {sl[14:0], sl[15] ^ sl[13] ^ sl[12] ^ sl[10]};
      cmd_ready = sl[0] | sl[3];
    end else begin
      cmd_ready = 1'b1;
    end
    #1;
    if (done) begin
      done_cnt++;
      done_valid = cmd_valid;
    end
    if (prev_stall) begin
      if (!cmd_valid || cmd_addr != p_addr || cmd_data != p_data || cmd_instr != p_instr)
        hold_bad++;
    end
    prev_stall = cmd_valid && !cmd_ready && !load_i;
    if (prev_stall) stall_cnt++;
    p_addr = cmd_addr;
    p_data = cmd_data;
    p_instr = cmd_instr;
    if (cmd_valid && cmd_ready && !load_i && ncap < 512) begin
      cap_addr[ncap]  = cmd_addr;
      cap_data[ncap]  = cmd_data;
      cap_instr[ncap] = cmd_instr;
      ncap++;
    end
  end

  task automatic set_cfg(logic [1:0] am, logic [3:0] im, logic [1:0] bm, logic [3:0] dm,
                         logic [31:0] s, logic [31:0] e, logic [2:0] fi, logic [5:0] fb,
                         logic [31:0] fd);
    amode = am; imode = im; bmode = bm; dmode = dm;
    start_a = s; end_a = e; finstr = fi; fburst = fb; fdata = fd;
  endtask

  task automatic do_load();
    @(negedge clk);
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
    ncap = 0; done_cnt = 0; hold_bad = 0; stall_cnt = 0; done_valid = 1'b0;
  endtask

  task automatic wait_done(int limit);
    for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    #2;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    #2;
    chk("R1 valid after reset", cmd_valid == 1'b0, 32'(cmd_valid), 32'd0);
    chk("R1 done after reset", done == 1'b0, 32'(done), 32'd0);
    chk("R1 nothing issued", ncap == 0, 32'(ncap), 32'd0);
  endtask

  task automatic t_seq_addr();
    int bad_d = 0, bad_i = 0;
    stall_en = 1'b0;
    set_cfg(2'b11, 4'b0001, 2'b01, 4'b0010, 32'h100, 32'h13C, 3'b000, 6'd16, 32'h0);
    do_load();
    wait_done(200);
    chk("R3 command count", ncap == 8, 32'(ncap), 32'd8);
    for (int i = 0; i < 8; i++)
      chk("R3 sequential address", cap_addr[i] == 32'h100 + 32'(8 * i), cap_addr[i], 32'h100 + 32'(8 * i));
    for (int i = 0; i < ncap; i++) begin
      if (cap_data[i] != cap_addr[i]) bad_d++;
      if (cap_instr[i] != 3'b000) bad_i++;
    end
    chk("R7 data equals address", bad_d == 0, 32'(bad_d), 32'd0);
    chk("R5 fixed write instruction", bad_i == 0, 32'(bad_i), 32'd0);
    chk("R3 single done pulse", done_cnt == 1, 32'(done_cnt), 32'd1);
    chk("R3 idle at done", done_valid == 1'b0, 32'(done_valid), 32'd0);
    chk("R3 idle after run", cmd_valid == 1'b0, 32'(cmd_valid), 32'd0);
  endtask

  task automatic t_fixed_stall();
    int bad_d = 0, bad_i = 0, bad_a = 0;
    stall_en = 1'b1;
    set_cfg(2'b11, 4'b0001, 2'b01, 4'b0001, 32'h0, 32'h3F8, 3'b001, 6'd8, 32'hDEAD_BEEF);
    do_load();
    // change everything without a load: must be ignored
    set_cfg(2'b00, 4'b0000, 2'b00, 4'b0010, 32'h500, 32'h10, 3'b000, 6'd3, 32'h0);
    wait_done(2000);
    chk("R2 command count unchanged", ncap == 128, 32'(ncap), 32'd128);
    for (int i = 0; i < ncap; i++) begin
      if (cap_data[i] != 32'hDEAD_BEEF) bad_d++;
      if (cap_instr[i] != 3'b001) bad_i++;
      if (cap_addr[i] != 32'(8 * i)) bad_a++;
    end
    chk("R8 fixed data word", bad_d == 0, 32'(bad_d), 32'd0);
    chk("R2 R5 fixed read instruction kept", bad_i == 0, 32'(bad_i), 32'd0);
    chk("R2 addresses from captured window", bad_a == 0, 32'(bad_a), 32'd0);
    chk("R10 stalls occurred", stall_cnt > 0, 32'(stall_cnt), 32'd1);
    chk("R10 held while stalled", hold_bad == 0, 32'(hold_bad), 32'd0);
    stall_en = 1'b0;
  endtask

  task automatic t_repeat();
    int bad = 0;
    stall_en = 1'b1;
    set_cfg(2'b11, 4'b0001, 2'b01, 4'b0011, 32'h0, 32'h98, 3'b000, 6'd1, 32'h0);
    do_load();
    wait_done(500);
    chk("R9 command count", ncap == 20, 32'(ncap), 32'd20);
    for (int i = 0; i < ncap; i++)
      if (cap_data[i] != rep_word(i % 8)) bad++;
    chk("R9 repeat word order", bad == 0, 32'(bad), 32'd0);
    chk("R9 ninth word wraps", cap_data[8] == rep_word(0), cap_data[8], rep_word(0));
    stall_en = 1'b0;
  endtask

  task automatic t_prbs();
    int out_win = 0, bad_grp = 0, bad_code = 0, n_wr = 0, n_rd = 0, n_diff = 0;
    set_cfg(2'b00, 4'b0000, 2'b01, 4'b0010, 32'h1000, 32'h1FFF, 3'b000, 6'd4, 32'h0);
    do_load();
    for (int i = 0; i < 2000 && ncap < 256; i++) @(negedge clk);
    #2;
    chk("R4 enough commands", ncap >= 256, 32'(ncap), 32'd256);
    for (int i = 0; i < 256; i++) begin
      if (cap_addr[i] < 32'h1000 || cap_addr[i] > 32'h1FFF) out_win++;
      if (i > 0 && cap_addr[i] != cap_addr[i-1]) n_diff++;
      if (cap_instr[i] == 3'b000) n_wr++;
      else if (cap_instr[i] == 3'b001) n_rd++;
      else bad_code++;
      if ((i % 4) != 0 && cap_instr[i] != cap_instr[i-1]) bad_grp++;
    end
    chk("R4 addresses in window", out_win == 0, 32'(out_win), 32'd0);
    chk("R4 addresses vary", n_diff > 128, 32'(n_diff), 32'd129);
    chk("R4 no done in random run", done_cnt == 0, 32'(done_cnt), 32'd0);
    chk("R5 only write or read codes", bad_code == 0, 32'(bad_code), 32'd0);
    chk("R5 writes present", n_wr > 0, 32'(n_wr), 32'd1);
    chk("R5 reads present", n_rd > 0, 32'(n_rd), 32'd1);
    chk("R6 burst groups of four", bad_grp == 0, 32'(bad_grp), 32'd0);
  endtask

  task automatic t_reload();
    set_cfg(2'b11, 4'b0001, 2'b01, 4'b0001, 32'h0, 32'hFFF8, 3'b000, 6'd2, 32'h1234_5678);
    do_load();
    repeat (10) @(negedge clk);
    set_cfg(2'b11, 4'b0001, 2'b01, 4'b0010, 32'h2000, 32'h2040, 3'b001, 6'd2, 32'h0);
    do_load();
    #2;
    chk("R11 gap after load", cmd_valid == 1'b0, 32'(cmd_valid), 32'd0);
    @(negedge clk);
    #2;
    chk("R11 new command valid", cmd_valid == 1'b1, 32'(cmd_valid), 32'd1);
    chk("R11 new start address", cmd_addr == 32'h2000, cmd_addr, 32'h2000);
    chk("R11 new instruction", cmd_instr == 3'b001, 32'(cmd_instr), 32'd1);
    wait_done(200);
    chk("R11 R3 inclusive end count", ncap == 9, 32'(ncap), 32'd9);
    chk("R3 last address at end", cap_addr[8] == 32'h2040, cap_addr[8], 32'h2040);
  endtask

  initial begin
    rst_n = 1'b0;
    load_i = 1'b0;
    cmd_ready = 1'b1;
    set_cfg(2'b00, 4'b0000, 2'b00, 4'b0000, 32'h0, 32'h0, 3'b000, 6'd0, 32'h0);
    for (int k = 0; k < 8; k++) rep[32*k +: 32] = rep_word(k);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_seq_addr();
    t_fixed_stall();
    t_repeat();
    t_prbs();
    t_reload();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule